// File: doc/BRIEF.md
# Frame-Start Pulse Detector for a Dot-Matrix Display Bus

This block watches the display-enable line of a dot-matrix display bus and tells the rest of the chip when a new frame begins. It has no dedicated frame-sync signal to use. Instead, it measures a low interval on the enable line. Once the line falls, the detector waits a programmed number of timing ticks. It then samples the line once and decides from that one sample whether the interval marked a frame boundary. When it finds a boundary, it emits a single-cycle pulse.

Two decision polarities are available, so one design covers two display families. In the first, a line that has already returned high at the sample point means a frame starts. In the second, a line that is still low at the sample point means a frame starts, and a line that has gone high means it does not. The timing logic counts ticks of a nominal 125 MHz reference. When the system clock is faster, a clock-enable divider set to the integer ratio of the two clocks produces those ticks. The delay count is a port value; it is captured when a measurement starts, so it must be stable while the detector is enabled.

Top module: `frame_start_detector`

## Requirements
- R1: After reset the frame-start output is low, and it stays low for as long as the enable line stays high.
- R2: With mode_i = 0, a low interval that has ended by the sample point gives exactly one single-cycle pulse. With a divider of 1, the pulse is high in the cycle that follows clock edge k+N+4, where the line was driven low just after edge k and N is the delay count. The extra 4 cycles are 2 for synchronization, 1 to arm, and 1 for the zero-count sample.
- R3: With mode_i = 0, a line still low at the sample point gives no pulse. The detector re-arms only after the line has gone high, and the next low interval that is short enough is then detected.
- R4: With mode_i = 1, a line still low at the sample point gives one pulse, with the same latency as in R2. A line already high at the sample point gives none.
- R5: With mode_i = 1, no further pulse follows within the same low interval. A new pulse needs the line to go high and then low again.
- R6: A delay count of 0 samples on the tick after arming, so the pulse follows edge k+4.
- R7: While clr_i is high, the detector returns to its idle wait and the output is forced low, which drops any pending pulse. After clr_i is released, detection works again.
- R8: While en_i is low, no measurement starts and the output stays low.
- R9: The delay is counted in ticks of the divider, which produce one tick every TICK_DIV clocks. The output pulse is one system clock wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_i | input | 1 | Detector enable; when low the detector is held idle |
| clr_i | input | 1 | Synchronous clear back to the idle wait |
| mode_i | input | 1 | Decision polarity: 0 = high sample is a frame, 1 = low sample is a frame |
| delay_i | input | DLY_W | Delay count in ticks, captured when a measurement starts |
| de_i | input | 1 | Asynchronous display-enable line |
| fs_o | output | 1 | Single-cycle frame-start pulse |

## Verification
The bench drives two instances from the same stimulus. One is built with TICK_DIV = 1, so every clock is a tick and the pulse latency can be checked to the exact cycle. The other is built with TICK_DIV = 3, where a low interval that is too long for the first instance still ends before the second instance samples. That shows the delay is counted in ticks and not in clocks. Both use DLY_W = 12, and short delay counts of 0 to 20 keep each scenario to a few dozen cycles while still reaching the zero-count case and the boundaries between short and long low intervals.

// File: rtl/fsd_pkg.sv
// Package: shared types for the frame-start detector.
// Assumes: nothing beyond IEEE 1800-2017.
package fsd_pkg;
    typedef enum logic [1:0] {
        ST_WAIT_LOW  = 2'd0,
        ST_DELAY     = 2'd1,
        ST_WAIT_HIGH = 2'd2
    } fsd_state_t;

    localparam logic MODE_HIGH_IS_FRAME = 1'b0;
    localparam logic MODE_LOW_IS_FRAME  = 1'b1;
endpackage

// File: rtl/fsd_sync.sv
// Module: fsd_sync
// Brings an asynchronous level into the clock domain through a flop chain.
// Assumes: STAGES >= 2; the reset value matches the idle level of the line.
module fsd_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    // Shift the input through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= {chain_q[STAGES-2:0], d_i};
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/fsd_tick.sv
// Module: fsd_tick
// Produces a clock enable once every DIV system clocks, which recreates the
// reference timing base on a faster clock.
// Assumes: DIV >= 1; DIV = 1 gives a tick on every clock.
module fsd_tick #(
    parameter int DIV = 1
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    generate
        if (DIV <= 1) begin : g_every
            assign tick_o = 1'b1;
        end else begin : g_div
            localparam int CW = $clog2(DIV);
            localparam logic [CW-1:0] LAST = CW'(DIV - 1);
            logic [CW-1:0] div_q;

            // Count system clocks modulo DIV.
            always_ff @(posedge clk) begin
                if (!rst_n)             div_q <= '0;
                else if (div_q == LAST) div_q <= '0;
                else                    div_q <= div_q + 1'b1;
            end

            assign tick_o = (div_q == '0);

            AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
                tick_o |=> !tick_o); // R9
        end
    endgenerate
endmodule

// File: rtl/fsd_timer.sv
// Module: fsd_timer
// Down-counter for the sampling delay. A load captures the count, and each
// dec step lowers it by one.
// Assumes: the caller only asserts dec while the count is nonzero.
module fsd_timer #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    input  logic         dec_i,
    output logic         zero_o
);
    logic [W-1:0] cnt_q;

    // Load on arm, otherwise count down on each step.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= '0;
        else if (load_i) cnt_q <= load_val_i;
        else if (dec_i)  cnt_q <= cnt_q - 1'b1;
    end

    assign zero_o = (cnt_q == '0);

    AST_TIMER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !dec_i) |=> $stable(cnt_q)); // R9
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_i && !load_i) |-> !zero_o); // R6
endmodule

// File: rtl/frame_start_detector.sv
// Module: frame_start_detector (top)
// Finds frame starts on a display-enable line. A measurement starts when the
// line is low, waits delay_i ticks, samples the line once and decides by
// mode_i. Output is a one-system-clock pulse.
// Assumes: de_i is asynchronous; delay_i and mode_i are static while en_i=1.
module frame_start_detector #(
    parameter int DLY_W    = 12,
    parameter int TICK_DIV = 1,
    parameter int SYNC_STG = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             clr_i,
    input  logic             mode_i,
    input  logic [DLY_W-1:0] delay_i,
    input  logic             de_i,
    output logic             fs_o
);
    import fsd_pkg::*;

    fsd_state_t state_q;
    logic       de_s;
    logic       tick;
    logic       zero;
    logic       run;
    logic       arm;
    logic       decide;
    logic       hit;
    logic       fs_q;

    fsd_sync #(.STAGES(SYNC_STG), .RST_VAL(1'b1)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_i(de_i), .q_o(de_s)
    );

    fsd_tick #(.DIV(TICK_DIV)) u_tick (
        .clk(clk), .rst_n(rst_n), .tick_o(tick)
    );

    // Qualify the per-tick events of the state machine.
    always_comb begin
        run    = en_i && !clr_i && tick;
        arm    = run && (state_q == ST_WAIT_LOW) && !de_s;
        decide = run && (state_q == ST_DELAY) && zero;
        hit    = (mode_i == MODE_LOW_IS_FRAME) ? !de_s : de_s;
    end

    fsd_timer #(.W(DLY_W)) u_timer (
        .clk(clk), .rst_n(rst_n),
        .load_i(arm), .load_val_i(delay_i),
        .dec_i(run && (state_q == ST_DELAY) && !zero),
        .zero_o(zero)
    );

    // Sample-and-decide state machine with the registered pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_WAIT_LOW;
            fs_q    <= 1'b0;
        end else if (clr_i || !en_i) begin
            state_q <= ST_WAIT_LOW;
            fs_q    <= 1'b0;
        end else begin
            fs_q <= decide && hit;
            if (run) begin
                case (state_q)
                    ST_WAIT_LOW:  if (!de_s) state_q <= ST_DELAY;
                    ST_DELAY: if (zero) begin
                        if (mode_i == MODE_LOW_IS_FRAME)
                            state_q <= de_s ? ST_WAIT_LOW : ST_WAIT_HIGH;
                        else
                            state_q <= de_s ? ST_WAIT_LOW : ST_WAIT_HIGH;
                    end
                    ST_WAIT_HIGH: if (de_s) state_q <= ST_WAIT_LOW;
                    default:      state_q <= ST_WAIT_LOW;
                endcase
            end
        end
    end

    assign fs_o = fs_q;

    AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        fs_o |=> !fs_o); // R2
    AST_CLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (!fs_o && state_q == ST_WAIT_LOW)); // R7
    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !fs_o); // R8
    AST_PULSE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        fs_o |-> $past(tick)); // R9
    AST_ALT_NO_REPEAT: assert property (@(posedge clk) disable iff (!rst_n)
        (fs_o && mode_i == MODE_LOW_IS_FRAME && !clr_i && en_i)
            |-> state_q == ST_WAIT_HIGH); // R5
endmodule

// File: tb/tb_frame_start_detector.sv
// Bench: directed scenarios, one task each, on two instances sharing stimulus.
module tb_frame_start_detector;
    localparam int DW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          en_i = 1'b0;
    logic          clr_i = 1'b0;
    logic          mode_i = 1'b0;
    logic [DW-1:0] delay_i = '0;
    logic          de_i = 1'b1;
    logic          fs_o;
    logic          fs2_o;

    int cyc = 0;
    int checks = 0;
    int failures = 0;
    int n1 = 0;
    int n2 = 0;
    int last1 = -1;

    always #5 clk = ~clk;

    frame_start_detector #(.DLY_W(DW), .TICK_DIV(1)) dut (
        .clk(clk), .rst_n(rst_n), .en_i(en_i), .clr_i(clr_i), .mode_i(mode_i),
        .delay_i(delay_i), .de_i(de_i), .fs_o(fs_o)
    );

    frame_start_detector #(.DLY_W(DW), .TICK_DIV(3)) dut_div (
        .clk(clk), .rst_n(rst_n), .en_i(en_i), .clr_i(clr_i), .mode_i(mode_i),
        .delay_i(delay_i), .de_i(de_i), .fs_o(fs2_o)
    );

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (fs_o) begin
            n1 <= n1 + 1;
            last1 <= cyc;
        end
        if (fs2_o) n2 <= n2 + 1;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        de_i = 1'b1;
        repeat (n) @(negedge clk);
        n1 = 0;
        n2 = 0;
        last1 = -1;
    endtask

    // Drive a low interval of len cycles; returns the edge index k before it.
    task automatic low_pulse(input int len, output int k);
        @(negedge clk);
        k = cyc;
        de_i = 1'b0;
        repeat (len) @(negedge clk);
        de_i = 1'b1;
    endtask

    task automatic t_reset();
        check(fs_o == 1'b0, "R1 reset output", fs_o, 0);
        idle(30);
        repeat (30) @(negedge clk);
        check(n1 == 0, "R1 no pulse while line high", n1, 0);
    endtask

    task automatic t_default_short(input int n, input int len);
        int k;
        idle(150);
        mode_i = 1'b0;
        delay_i = DW'(n);
        low_pulse(len, k);
        repeat (n + 20) @(negedge clk);
        check(n1 == 1, "R2 one pulse on short low", n1, 1);
        check(last1 - k == n + 4, "R2 latency", last1 - k, n + 4);
    endtask

    task automatic t_default_long();
        int k;
        idle(150);
        mode_i = 1'b0;
        delay_i = DW'(20);
        low_pulse(40, k);
        repeat (10) @(negedge clk);
        check(n1 == 0, "R3 no pulse on long low", n1, 0);
        low_pulse(5, k);
        repeat (40) @(negedge clk);
        check(n1 == 1, "R3 re-armed after high", n1, 1);
    endtask

    task automatic t_alt_long();
        int k;
        idle(150);
        mode_i = 1'b1;
        delay_i = DW'(20);
        low_pulse(60, k);
        check(n1 == 1, "R4 pulse on long low", n1, 1);
        check(last1 - k == 24, "R4 latency", last1 - k, 24);
        repeat (10) @(negedge clk);
        check(n1 == 1, "R5 no repeat in same low", n1, 1);
        repeat (5) @(negedge clk);
        low_pulse(40, k);
        repeat (5) @(negedge clk);
        check(n1 == 2, "R5 new pulse after high then low", n1, 2);
    endtask

    task automatic t_alt_short();
        int k;
        idle(150);
        mode_i = 1'b1;
        delay_i = DW'(20);
        low_pulse(10, k);
        repeat (40) @(negedge clk);
        check(n1 == 0, "R4 no pulse on short low", n1, 0);
        mode_i = 1'b0;
    endtask

    task automatic t_zero();
        int k;
        idle(150);
        mode_i = 1'b0;
        delay_i = '0;
        low_pulse(1, k);
        repeat (20) @(negedge clk);
        check(n1 == 1, "R6 zero delay pulse", n1, 1);
        check(last1 - k == 4, "R6 zero delay latency", last1 - k, 4);
    endtask

    task automatic t_clear();
        int k;
        idle(150);
        mode_i = 1'b0;
        delay_i = DW'(20);
        @(negedge clk);
        clr_i = 1'b1;
        low_pulse(10, k);
        repeat (20) @(negedge clk);
        clr_i = 1'b0;
        repeat (40) @(negedge clk);
        check(n1 == 0, "R7 clear drops pending pulse", n1, 0);
        low_pulse(10, k);
        repeat (40) @(negedge clk);
        check(n1 == 1, "R7 detection after clear", n1, 1);
    endtask

    task automatic t_disable();
        int k;
        idle(150);
        mode_i = 1'b0;
        delay_i = DW'(20);
        en_i = 1'b0;
        low_pulse(10, k);
        repeat (40) @(negedge clk);
        check(n1 == 0, "R8 disabled no pulse", n1, 0);
        en_i = 1'b1;
    endtask

    task automatic t_divider();
        int k;
        idle(150);
        mode_i = 1'b0;
        delay_i = DW'(10);
        low_pulse(20, k);
        repeat (60) @(negedge clk);
        check(n1 == 0, "R9 undivided sees long low", n1, 0);
        check(n2 == 1, "R9 divided counts ticks", n2, 1);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        en_i = 1'b1;
        t_reset();
        t_default_short(20, 10);
        t_default_short(5, 3);
        t_default_long();
        t_alt_long();
        t_alt_short();
        t_zero();
        t_clear();
        t_disable();
        t_divider();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule